// File: doc/BRIEF.md
# Sixteen-Pin I/O Port with Per-Bit Output Update

The block is a general-purpose I/O port for sixteen pins, reached through a simple memory-mapped register bus. Each pin has a 4-bit setup nibble. The nibbles are split over two 32-bit words: one word covers pins 0 to 7 and the other covers pins 8 to 15. The two low bits of a nibble pick the drive mode, and the two high bits hold a configuration field. Any nonzero mode makes the pin drive its output. The block keeps no state about pad electrical behaviour.

Software reads the pin levels through an input word. The pins are resynchronized before that word sees them. Software writes all outputs at once through an output word. It can also change single output bits, with no read-modify-write, through two write-only words. The first word sets some bits and clears others in one write. The second word only clears bits. The pad side gets a per-pin output value and a per-pin output enable.

Read data is registered. The value for the address presented in cycle N appears on the read port after the clock edge that ends cycle N.

Top module: `gpio_port`

## Requirements
- R1: After reset, every setup nibble reads as 0x4, the output word reads 0, and all output values and output enables are low.
- R2: The setup word at offset 0x00 serves pins 0-7 and the one at 0x04 serves pins 8-15. Pin p uses bits [4(p mod 8)+3 : 4(p mod 8)] of its word. Both words are fully writable and read back as written.
- R3: The output enable of pin p is high exactly when bits [1:0] of its nibble are nonzero. A nibble of 0x3 enables the pin, and a nibble of 0x8 or 0x4 disables it.
- R4: The input word at offset 0x08 returns the pin levels in bits [15:0]. A pin change seen at one clock edge passes through two synchronizing flops. A read presented in the same cycle as the change, or one cycle later, returns the old level. A read presented two cycles later returns the new level.
- R5: A write to the output word at offset 0x0C replaces all sixteen output values with write-data bits [15:0]. The output pins follow from the next clock edge, and the word reads back in bits [15:0].
- R6: A write to offset 0x10 drives high each output whose bit in [15:0] is 1. It drives low each output whose bit in [31:16] is 1. Outputs with both bits 0 keep their value.
- R7: If one write to offset 0x10 sets both the high bit and the low bit of the same pin, the output ends high.
- R8: A write to offset 0x14 drives low each output whose bit in [15:0] is 1. Bits [31:16] of that write have no effect.
- R9: Reads of offsets 0x10 and 0x14 return zero.
- R10: Bits [31:16] of the input and output words read as zero, and writes to those bits are ignored. A write to the input word changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, acts at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 16 | Raw pin levels, asynchronous to clk |
| pin_out | output | 16 | Per-pin output value |
| pin_oe | output | 16 | Per-pin output enable |

## Verification
The assertions assume that the bus makes at most one access per cycle, that the address and write strobe are steady across each rising edge, and that the pin inputs settle for at least two cycles before the synchronizer check relies on them. The bench changes the bus and the pins only on falling edges and holds each write strobe for exactly one rising edge. It also keeps the strobe low during reset, so that every post-reset assertion starts from a known register state.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int ADDR_W        = 8;
  localparam int DATA_W        = 32;
  localparam int NIB_W         = 4;
  localparam int HALF_W        = DATA_W / 2;
  localparam int PINS_PER_WORD = DATA_W / NIB_W;

  localparam logic [ADDR_W-1:0] OFS_CFG_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IN     = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_OUT    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_SETCLR = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 8'h14;

  localparam logic [NIB_W-1:0] CFG_RESET_NIB = 4'h4;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int NPINS  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_sync
);
  logic [NPINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];

  // checker: count edges since reset before trusting history
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (pin_sync == $past(pin_in, 2))) else $error("sync latency"); // R4
    end
  endgenerate
endmodule

// File: rtl/gpio_cfg_bank.sv
`timescale 1ns/1ps
module gpio_cfg_bank
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [(NPINS+PINS_PER_WORD-1)/PINS_PER_WORD-1:0] wr_sel,
  input  logic [DATA_W-1:0]           wdata,
  output logic [((NPINS+PINS_PER_WORD-1)/PINS_PER_WORD)*DATA_W-1:0] cfg_flat,
  output logic [NPINS-1:0]            pin_drive
);
  localparam int NWORDS = (NPINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
  localparam logic [DATA_W-1:0] WORD_RESET = {PINS_PER_WORD{CFG_RESET_NIB}};

  logic [DATA_W-1:0] cfg_q [NWORDS];

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)            cfg_q[w] <= WORD_RESET;
        else if (wr_sel[w]) cfg_q[w] <= wdata;
      end
      assign cfg_flat[w*DATA_W +: DATA_W] = cfg_q[w];
    end
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign pin_drive[p] = |cfg_q[p / PINS_PER_WORD][NIB_W*(p % PINS_PER_WORD) +: 2];
    end
  endgenerate

  AST_CFG_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_flat == {NWORDS{WORD_RESET}})) else $error("cfg reset"); // R1
  AST_CFG_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel)) else $error("cfg select"); // R2
  AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_sel[0] |=> (cfg_flat[DATA_W-1:0] == $past(wdata))) else $error("cfg write"); // R2
endmodule

// File: rtl/gpio_out_latch.sv
`timescale 1ns/1ps
module gpio_out_latch
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_all,
  input  logic              ld_setclr,
  input  logic              ld_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPINS-1:0]  out_q
);
  logic [NPINS-1:0] set_bits, clr_bits, lo_bits, out_d;

  assign lo_bits  = wdata[NPINS-1:0];
  assign set_bits = ld_setclr ? lo_bits : '0;
  assign clr_bits = ld_setclr ? wdata[HALF_W +: NPINS] : (ld_clr ? lo_bits : '0);

  always_comb begin
    if (ld_all) out_d = lo_bits;
    else        out_d = (out_q & ~clr_bits) | set_bits;
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= out_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ld_setclr |=> ((out_q & $past(lo_bits)) == $past(lo_bits))) else $error("set lost"); // R7
  AST_SETCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ld_setclr |=> ((out_q & $past(wdata[HALF_W +: NPINS] & ~lo_bits)) == '0)) else $error("clr lost"); // R6
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ld_clr && !ld_all && !ld_setclr) |=> ((out_q & $past(lo_bits)) == '0)) else $error("clr-only"); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(ld_all || ld_setclr || ld_clr) |=> $stable(out_q)) else $error("out moved"); // R10
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    $countones({ld_all, ld_setclr, ld_clr}) <= 1) else $error("load overlap"); // R5
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  localparam int NWORDS = (NPINS + PINS_PER_WORD - 1) / PINS_PER_WORD;

  logic [NWORDS-1:0]        cfg_sel;
  logic [NWORDS*DATA_W-1:0] cfg_flat;
  logic [NPINS-1:0]         pin_sync;
  logic [NPINS-1:0]         out_q;
  logic [DATA_W-1:0]        rd_next;

  generate
    for (genvar w = 0; w < NWORDS; w++) begin : g_dec
      localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(OFS_CFG_LO + 4 * w);
      assign cfg_sel[w] = bus_we && (bus_addr == CFG_ADDR);
    end
  endgenerate

  gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  gpio_cfg_bank #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst(rst), .wr_sel(cfg_sel), .wdata(bus_wdata),
    .cfg_flat(cfg_flat), .pin_drive(pin_oe)
  );

  gpio_out_latch #(.NPINS(NPINS)) u_out (
    .clk(clk), .rst(rst),
    .ld_all   (bus_we && (bus_addr == OFS_OUT)),
    .ld_setclr(bus_we && (bus_addr == OFS_SETCLR)),
    .ld_clr   (bus_we && (bus_addr == OFS_CLR)),
    .wdata(bus_wdata), .out_q(out_q)
  );

  assign pin_out = out_q;

  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (bus_addr == ADDR_W'(OFS_CFG_LO + 4 * w)) rd_next = cfg_flat[w*DATA_W +: DATA_W];
    end
    if (bus_addr == OFS_IN)  rd_next[NPINS-1:0] = pin_sync;
    if (bus_addr == OFS_OUT) rd_next[NPINS-1:0] = out_q;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((bus_addr == OFS_SETCLR) || (bus_addr == OFS_CLR)) |=> (bus_rdata == '0)) else $error("wo read"); // R9
  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_OUT && !bus_we) |=> (bus_rdata == DATA_W'($past(pin_out)))) else $error("out readback"); // R5
  AST_OE_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_oe == '0 && pin_out == '0)) else $error("pins reset"); // R1
endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  localparam int NPINS = 16;

  typedef struct {
    string       req;
    logic [31:0] exp;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  logic rd_valid = 1'b0;
  exp_t sb_q[$];

  logic [31:0] cfg_m [2];
  logic [15:0] out_m;
  logic [15:0] in_m;

  gpio_port #(.NPINS(NPINS)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] oe_model();
    logic [15:0] r;
    for (int p = 0; p < 16; p++) r[p] = |cfg_m[p/8][4*(p%8) +: 2];
    return r;
  endfunction

  // monitor: pops scoreboard entries as read data appears
  always @(posedge clk) begin
    if (rd_valid) begin
      #2;
      if (sb_q.size() == 0) chk("SCOREBOARD", 32'h1, 32'h0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, bus_rdata, e.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
    case (a)
      8'h00: cfg_m[0] = d;
      8'h04: cfg_m[1] = d;
      8'h0C: out_m = d[15:0];
      8'h10: out_m = (out_m & ~d[31:16]) | d[15:0];
      8'h14: out_m = out_m & ~d[15:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    exp_t e;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0; rd_valid = 1'b1;
    e.req = req; e.exp = exp; sb_q.push_back(e);
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  task automatic chk_pins(input string req);
    @(negedge clk);
    chk({req, " pin_out"}, {16'h0, pin_out}, {16'h0, out_m});
    chk({req, " pin_oe"},  {16'h0, pin_oe},  {16'h0, oe_model()});
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cfg_m[0] = 32'h4444_4444; cfg_m[1] = 32'h4444_4444; out_m = '0; in_m = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk_pins("R1");
    rd(8'h00, 32'h4444_4444, "R1 cfg lo");
    rd(8'h04, 32'h4444_4444, "R1 cfg hi");
    rd(8'h0C, 32'h0, "R1 out word");

    // R2/R3 setup words: pins 0,3,4 as 0x3, pins 1,6,7 as 0x8, pins 2,5 left at 0x4
    wr(8'h00, 32'h8843_3483);
    rd(8'h00, 32'h8843_3483, "R2 cfg lo readback");
    chk_pins("R3 lo word");
    chk("R3 oe pattern", {16'h0, pin_oe}, 32'h0000_0019);
    // high word mixes mode 1, 2 and a nibble with cnf set but mode 0
    wr(8'h04, 32'h3333_2C13);
    rd(8'h04, 32'h3333_2C13, "R2 cfg hi readback");
    chk_pins("R3 hi word");

    // R5 / R10 output word
    wr(8'h0C, 32'hABCD_1234);
    chk_pins("R5 out write");
    rd(8'h0C, 32'h0000_1234, "R10 out upper zero");
    wr(8'h0C, 32'h0000_FFFF);
    rd(8'h0C, 32'h0000_FFFF, "R5 out replace");
    wr(8'h0C, 32'hFFFF_1234);

    // R6 set and clear in one write
    wr(8'h10, 32'h00F0_000F);
    chk_pins("R6 setclr");
    chk("R6 value", {16'h0, pin_out}, 32'h0000_120F);
    wr(8'h10, 32'h0000_0000);
    chk_pins("R6 zero write keeps");

    // R7 both bits for pins 4 and 8: set must win
    wr(8'h10, 32'h0110_0110);
    chk_pins("R7 set wins");
    chk("R7 value", {16'h0, pin_out}, 32'h0000_131F);

    // R8 clear-only, upper half ignored
    wr(8'h14, 32'hFFFF_0201);
    chk_pins("R8 clr only");
    chk("R8 value", {16'h0, pin_out}, 32'h0000_111E);

    // R9 write-only words read zero
    rd(8'h10, 32'h0, "R9 setclr read");
    rd(8'h14, 32'h0, "R9 clr read");

    // R10 write to input word has no effect
    wr(8'h08, 32'hFFFF_FFFF);
    chk_pins("R10 input write ignored");
    rd(8'h08, 32'h0, "R10 input unchanged");
    rd(8'h0C, {16'h0, out_m}, "R10 out after input write");

    // R4 synchronizer latency
    @(negedge clk);
    pin_in = 16'hA5C3;
    bus_addr = 8'h08; rd_valid = 1'b1;
    begin exp_t e; e.req = "R4 same cycle old"; e.exp = {16'h0, in_m}; sb_q.push_back(e); end
    @(posedge clk); #1 rd_valid = 1'b0;
    rd(8'h08, {16'h0, in_m}, "R4 one cycle old");
    in_m = 16'hA5C3;
    rd(8'h08, {16'h0, in_m}, "R4 two cycles new");
    pin_in = 16'h3C5A; in_m = 16'h3C5A;
    repeat (3) @(negedge clk);
    rd(8'h08, {16'h0, in_m}, "R4 second pattern");

    // R2 unmapped offset reads zero, reset returns defaults
    rd(8'h18, 32'h0, "R9 unmapped read");
    @(negedge clk);
    rst = 1'b1; cfg_m[0] = 32'h4444_4444; cfg_m[1] = 32'h4444_4444; out_m = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_pins("R1 second reset");
    rd(8'h04, 32'h4444_4444, "R1 cfg hi after reset");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule